// File: doc/BRIEF.md
# Counter-Based Interrupt Aggregator

This block merges interrupt activity from one overview source and a set of controller cores into a single host interrupt line. Every source owns a free-running event counter that advances by one on each cycle its event input is high. Every source also holds an acknowledged value that the host writes back. A source has pending work while the two differ, so a burst of events collapses into one pending condition. That condition stays up until the host reports the exact count it has processed.

Masking uses a command word rather than a plain bit vector. Each source has a two-bit field in the word. One field code masks the source, one unmasks it, and the other two leave it as it is. The host can therefore change any subset of sources in one write, without reading the mask first. Masking only gates the interrupt output: counting carries on while a source is masked, so nothing is lost. The low byte of each counter is also presented as the index into that source's 256-entry message ring.

The event, mask and acknowledge inputs are single-cycle control strobes with no back-pressure: each is accepted on the clock edge where it is high. Readback is a combinational multiplexer selected by `rd_sel_i`.

Top module: `irq_count_aggregator`

## Requirements
- R1: After reset every source is masked (`masked_o` all ones), every counter and acknowledged value is zero, `pending_o` is zero and `irq_o` is low.
- R2: The mask command holds one two-bit field per source, and source k uses bits [2k+1:2k]. Source 0 is the overview source and source k+1 is core k. On a mask write, code 01 clears the source's mask and code 10 sets it. Codes 00 and 11 leave the mask bit unchanged.
- R3: Writing 0x55555555 (with the default 16 sources) unmasks every source in one write, visible on `masked_o` the cycle after.
- R4: A source's counter rises by exactly one for each clock edge at which its event input is high, and holds otherwise. The selected counter is visible on `rd_cnt_o`.
- R5: `pending_o[k]` is high exactly when counter k differs from acknowledged value k.
- R6: An acknowledge write stores `ack_val_i` as the acknowledged value of source `ack_sel_i`. Writing the current count clears pending. Writing a stale count leaves the source pending.
- R7: `irq_o` is high exactly when at least one source is both pending and unmasked. Pending on a masked source does not raise it.
- R8: Events counted while a source is masked raise `irq_o` in the cycle after that source is unmasked.
- R9: `rd_ring_o` is the low 8 bits of the selected counter. It wraps from 255 to 0 while the counter carries into bit 8.
- R10: When an event and an acknowledge for the same source land on the same edge, the counter still increments and the acknowledged value takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_SRC | Per-source event strobe, one count per high cycle |
| mask_we_i | input | 1 | Mask command write strobe |
| mask_cmd_i | input | 2*NUM_SRC | Packed two-bit mask commands, one field per source |
| ack_we_i | input | 1 | Acknowledge write strobe |
| ack_sel_i | input | SEL_W | Source addressed by the acknowledge write |
| ack_val_i | input | CNT_W | Processed counter value written back |
| rd_sel_i | input | SEL_W | Source whose counter is shown on the readback outputs |
| rd_cnt_o | output | CNT_W | Counter of the selected source |
| rd_ring_o | output | RING_W | Message ring index (low counter bits) of the selected source |
| pending_o | output | NUM_SRC | Per-source counter-differs-from-acknowledge flags |
| masked_o | output | NUM_SRC | Per-source mask state, 1 means masked |
| irq_o | output | 1 | Host interrupt request |

## Verification
The scoreboard first drives events into masked sources, so pending rises while the interrupt stays low. This separates the pending logic from the output gate. Mask words that mix all four field codes in one write show that each field is decoded on its own and that the two no-action codes really do nothing. A current acknowledge and a stale acknowledge are issued for the same source to show that only an exact match clears it. An acknowledge that coincides with an event shows that neither update is dropped. A long event run on one core pushes the ring index through its wrap while the full counter is compared alongside it.

// File: rtl/irq_count_pkg.sv
package irq_count_pkg;

  typedef enum logic [1:0] {
    MCMD_KEEP_LO = 2'b00,
    MCMD_UNMASK  = 2'b01,
    MCMD_MASK    = 2'b10,
    MCMD_KEEP_HI = 2'b11
  } mask_cmd_e;

  function automatic logic next_mask(input logic cur, input logic [1:0] code);
    case (code)
      MCMD_UNMASK: next_mask = 1'b0;
      MCMD_MASK:   next_mask = 1'b1;
      default:     next_mask = cur;
    endcase
  endfunction

endpackage

// File: rtl/src_event_counter.sv
module src_event_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             ack_we_i,
  input  logic [CNT_W-1:0] ack_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pending_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ack_q;

  // Counter wraps naturally at its maximum.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (evt_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= '0;
    end else if (ack_we_i) begin
      ack_q <= ack_val_i;
    end
  end

  assign cnt_o     = cnt_q;
  assign pending_o = (cnt_q != ack_q);
endmodule

// File: rtl/mask_cell.sv
module mask_cell
  import irq_count_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  logic [1:0] code_i,
  output logic       masked_o
);
  logic masked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      masked_q <= 1'b1;
    end else if (we_i) begin
      masked_q <= next_mask(masked_q, code_i);
    end
  end

  assign masked_o = masked_q;
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int NUM_SRC = 16
) (
  input  logic [NUM_SRC-1:0] pending_i,
  input  logic [NUM_SRC-1:0] masked_i,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] live;

  assign live  = pending_i & ~masked_i;
  assign irq_o = |live;
endmodule

// File: rtl/irq_count_aggregator.sv
module irq_count_aggregator #(
  parameter int NUM_CORES = 15,
  parameter int CNT_W     = 32,
  parameter int RING_W    = 8,
  localparam int NUM_SRC  = NUM_CORES + 1,
  localparam int SEL_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   evt_i,
  input  logic                 mask_we_i,
  input  logic [2*NUM_SRC-1:0] mask_cmd_i,
  input  logic                 ack_we_i,
  input  logic [SEL_W-1:0]     ack_sel_i,
  input  logic [CNT_W-1:0]     ack_val_i,
  input  logic [SEL_W-1:0]     rd_sel_i,
  output logic [CNT_W-1:0]     rd_cnt_o,
  output logic [RING_W-1:0]    rd_ring_o,
  output logic [NUM_SRC-1:0]   pending_o,
  output logic [NUM_SRC-1:0]   masked_o,
  output logic                 irq_o
);
  logic [NUM_SRC-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_SRC-1:0]            ack_hit;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign ack_hit[k] = ack_we_i && (ack_sel_i == SEL_W'(k));

    src_event_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt_i[k]),
      .ack_we_i  (ack_hit[k]),
      .ack_val_i (ack_val_i),
      .cnt_o     (cnt_q[k]),
      .pending_o (pending_o[k])
    );

    mask_cell u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (mask_we_i),
      .code_i   (mask_cmd_i[2*k +: 2]),
      .masked_o (masked_o[k])
    );
  end

  irq_merge #(.NUM_SRC(NUM_SRC)) u_merge (
    .pending_i (pending_o),
    .masked_i  (masked_o),
    .irq_o     (irq_o)
  );

  // Readback mux written as a loop so an out-of-range select reads zero.
  always_comb begin
    rd_cnt_o = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (rd_sel_i == SEL_W'(k)) rd_cnt_o = cnt_q[k];
    end
  end

  assign rd_ring_o = rd_cnt_o[RING_W-1:0];
endmodule

// File: rtl/irq_count_aggregator_chk.sv
module irq_count_aggregator_chk #(
  parameter int NUM_SRC = 16,
  parameter int CNT_W   = 32,
  parameter int SEL_W   = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_SRC-1:0]            evt_i,
  input logic                          mask_we_i,
  input logic [2*NUM_SRC-1:0]          mask_cmd_i,
  input logic                          ack_we_i,
  input logic [SEL_W-1:0]              ack_sel_i,
  input logic [CNT_W-1:0]              ack_val_i,
  input logic [NUM_SRC-1:0]            pending_o,
  input logic [NUM_SRC-1:0]            masked_o,
  input logic                          irq_o,
  input logic [NUM_SRC-1:0][CNT_W-1:0] cnt_q
);
  localparam logic [2*NUM_SRC-1:0] ALL_UNMASK = {NUM_SRC{2'b01}};
  localparam logic [2*NUM_SRC-1:0] ALL_MASK   = {NUM_SRC{2'b10}};

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (masked_o == '1 && pending_o == '0 && !irq_o));

  p_all_mask_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we_i && mask_cmd_i == ALL_MASK) |=> !irq_o);

  p_all_unmask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we_i && mask_cmd_i == ALL_UNMASK) |=> (masked_o == '0));

  p_ack_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we_i && !evt_i[ack_sel_i] && ack_val_i == cnt_q[ack_sel_i])
      |=> !pending_o[$past(ack_sel_i)]);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_chk
    p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[k] |=> (cnt_q[k] == $past(cnt_q[k]) + CNT_W'(1)));

    p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_i[k] |=> $stable(cnt_q[k]));

    p_keep_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_we_i && (mask_cmd_i[2*k +: 2] == 2'b00 || mask_cmd_i[2*k +: 2] == 2'b11))
        |=> $stable(masked_o[k]));

    p_unmask_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_we_i && mask_cmd_i[2*k +: 2] == 2'b01 && pending_o[k] && !ack_we_i)
        |=> irq_o);
  end
endmodule

bind irq_count_aggregator irq_count_aggregator_chk #(
  .NUM_SRC (NUM_SRC),
  .CNT_W   (CNT_W),
  .SEL_W   (SEL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_i      (evt_i),
  .mask_we_i  (mask_we_i),
  .mask_cmd_i (mask_cmd_i),
  .ack_we_i   (ack_we_i),
  .ack_sel_i  (ack_sel_i),
  .ack_val_i  (ack_val_i),
  .pending_o  (pending_o),
  .masked_o   (masked_o),
  .irq_o      (irq_o),
  .cnt_q      (cnt_q)
);

// File: tb/test_irq_count_aggregator.sv
module test_irq_count_aggregator;
  localparam int NS = 16;
  localparam int CW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NS-1:0]   evt = '0;
  logic            mask_we = 1'b0;
  logic [2*NS-1:0] mask_cmd = '0;
  logic            ack_we = 1'b0;
  logic [3:0]      ack_sel = '0;
  logic [CW-1:0]   ack_val = '0;
  logic [3:0]      rd_sel = '0;
  logic [CW-1:0]   rd_cnt;
  logic [7:0]      rd_ring;
  logic [NS-1:0]   pending;
  logic [NS-1:0]   masked;
  logic            irq;

  always #5 clk = ~clk;

  irq_count_aggregator i_irq_count_aggregator (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .mask_we_i(mask_we),
    .mask_cmd_i(mask_cmd), .ack_we_i(ack_we), .ack_sel_i(ack_sel),
    .ack_val_i(ack_val), .rd_sel_i(rd_sel), .rd_cnt_o(rd_cnt),
    .rd_ring_o(rd_ring), .pending_o(pending), .masked_o(masked), .irq_o(irq)
  );

  // Reference model built from the requirements.
  logic [CW-1:0] m_cnt [NS];
  logic [CW-1:0] m_ack [NS];
  logic [NS-1:0] m_mask;

  typedef struct { string tag; int kind; logic [31:0] exp; } item_t;
  item_t q[$];
  item_t it;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  function automatic logic [31:0] observe(int kind);
    case (kind)
      0: observe = {31'd0, irq};
      1: observe = {16'd0, pending};
      2: observe = {16'd0, masked};
      3: observe = rd_cnt;
      default: observe = {24'd0, rd_ring};
    endcase
  endfunction

  // Monitor: compares queued expectations in the low clock phase.
  always @(negedge clk) begin
    while (q.size() > 0) begin
      logic [31:0] act;
      it = q.pop_front();
      act = observe(it.kind);
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(string tag, int kind, logic [31:0] exp);
    item_t x;
    x.tag = tag; x.kind = kind; x.exp = exp;
    q.push_back(x);
  endtask

  task automatic drain();
    @(negedge clk); #1;
  endtask

  function automatic logic [NS-1:0] m_pend();
    logic [NS-1:0] p;
    for (int k = 0; k < NS; k++) p[k] = (m_cnt[k] != m_ack[k]);
    return p;
  endfunction

  task automatic check_all(string tag);
    logic [NS-1:0] p;
    p = m_pend();
    push(tag, 0, {31'd0, |(p & ~m_mask)});
    push(tag, 1, {16'd0, p});
    push(tag, 2, {16'd0, m_mask});
    drain();
  endtask

  task automatic check_cnt(int s, string tag);
    rd_sel = 4'(s);
    push(tag, 3, m_cnt[s]);
    push(tag, 4, {24'd0, m_cnt[s][7:0]});
    drain();
  endtask

  // Driver: one cycle of stimulus; the model follows R2, R4, R6 and R10.
  task automatic cycle(logic [NS-1:0] ev, logic mwe, logic [2*NS-1:0] mc,
                       logic awe, int as, logic [CW-1:0] av);
    evt = ev; mask_we = mwe; mask_cmd = mc;
    ack_we = awe; ack_sel = 4'(as); ack_val = av;
    @(posedge clk); #1;
    for (int k = 0; k < NS; k++) begin
      if (ev[k]) m_cnt[k] = m_cnt[k] + 1;
      if (mwe) begin
        if (mc[2*k +: 2] == 2'b01) m_mask[k] = 1'b0;
        else if (mc[2*k +: 2] == 2'b10) m_mask[k] = 1'b1;
      end
    end
    if (awe) m_ack[as] = av;
    evt = '0; mask_we = 1'b0; ack_we = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NS; k++) begin m_cnt[k] = '0; m_ack[k] = '0; end
    m_mask = '1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: reset state
    check_all("R1 reset");
    check_cnt(0, "R1 counter zero");

    // R4, R5, R7: events on masked sources raise pending but not irq
    cycle(16'h0009, 0, '0, 0, 0, '0);
    check_all("R7 masked pending");
    check_cnt(3, "R4 count src3");

    // R2, R8: unmask source 3 (01); field 0 code 11 and the rest 00 keep masks
    cycle('0, 1, 32'h0000_0043, 0, 0, '0);
    check_all("R8 unmask shows stored event");

    // R6: exact acknowledge clears pending
    cycle('0, 0, '0, 1, 3, 32'd1);
    check_all("R6 exact ack");

    // R4: two further events on source 3, one on source 5
    cycle(16'h0028, 0, '0, 0, 0, '0);
    cycle(16'h0008, 0, '0, 0, 0, '0);
    check_cnt(3, "R4 count after burst");
    // R6: stale acknowledge keeps source 3 pending
    cycle('0, 0, '0, 1, 3, 32'd1);
    check_all("R6 stale ack");

    // R2: mask source 3 with 10, code 11 on source 5 keeps it masked
    cycle('0, 1, 32'h0000_0C80, 0, 0, '0);
    check_all("R2 mask and keep");

    // R3: unmask every source in one write
    cycle('0, 1, 32'h5555_5555, 0, 0, '0);
    check_all("R3 unmask all");

    // R10: event and ack of source 0 on the same edge
    cycle(16'h0001, 0, '0, 1, 0, 32'd1);
    check_all("R10 event with ack");
    check_cnt(0, "R10 counter advanced");

    // R9: ring index wraps on core 6 (source 7)
    for (int n = 0; n < 255; n++) cycle(16'h0080, 0, '0, 0, 0, '0);
    check_cnt(7, "R9 ring at 255");
    cycle(16'h0080, 0, '0, 0, 0, '0);
    check_cnt(7, "R9 ring wrapped");

    // R6, R7: acknowledge everything, irq drops
    for (int k = 0; k < NS; k++) cycle('0, 0, '0, 1, k, m_cnt[k]);
    check_all("R7 all acked");

    // R2: full mask word, new event stays hidden
    cycle('0, 1, 32'hAAAA_AAAA, 0, 0, '0);
    cycle(16'h8000, 0, '0, 0, 0, '0);
    check_all("R2 mask all hides event");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule